// File: doc/BRIEF.md
# Cross-Domain FIFO with Early Flags

This block moves data words from a producer clocked by one clock to a consumer clocked by another. The two clocks have no known phase or frequency relationship. Each side can transfer one word on every rising edge of its own clock while the queue holds some data and has room. No per-word handshake is needed, provided each side obeys its flag.

The full flag is raised early, ahead of true fullness. A producer that needs a fixed number of cycles to react to the flag can therefore stream back to back and still stop exactly when the nominal depth is used. The words it issues during its reaction window land in spare slack entries. Storage is a register array sized to the next power of two at or above nominal depth plus slack. Read and write pointers carry one wrap bit and cross between the domains in Gray code through two-flop synchronizers. Each domain has its own active-low asynchronous reset.

The read port shows the oldest stored word whenever the empty flag is low. A read strobe moves on to the next word.

Top module: `xfifo_cdc`

## Requirements
- R1: After its domain's reset is released, full_o reads 0 and empty_o reads 1. This holds even if the queue was occupied before the reset.
- R2: Write-side occupancy is the number of words written minus the synchronized read count. full_o rises right after the write edge that brings this occupancy to DEPTH-RECOG, which is 15 with defaults. While full_o is low, that occupancy stays below DEPTH-RECOG.
- R3: A producer that reacts to full_o RECOG write cycles late writes exactly DEPTH words in an uninterrupted burst into an idle queue. Every word, including the ones written after full_o rose, is later read back in order.
- R4: Physical capacity CAP is 2 to the power ceil(log2(DEPTH+SLACK)), which is 32 with defaults. A write that arrives while the write side already counts CAP words is dropped. The first CAP words are kept in order.
- R5: With both sides transferring on every edge their flags permit, all words arrive once and in order. This holds for read periods shorter than, longer than and four times the write period.
- R6: After a write into an empty queue, empty_o stays 1 through the second read-clock rising edge that follows the write edge. It reads 0 after the third.
- R7: Suppose full_o is set and reads move the read pointer enough to drop occupancy below DEPTH-RECOG. full_o then stays 1 through the second write-clock rising edge after the last such read edge, and reads 0 after the third.
- R8: A read strobe while empty_o is 1 does not move the read pointer. The next word written is the next word read.
- R9: While empty_o is 0, rd_data_o shows the oldest unread word. It can be sampled before the strobe that consumes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Producer clock |
| wr_rst_ni | input | 1 | Producer-domain asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | DW | Word to store |
| full_o | output | 1 | Early full flag, producer domain |
| rd_clk_i | input | 1 | Consumer clock |
| rd_rst_ni | input | 1 | Consumer-domain asynchronous reset, active low |
| rd_i | input | 1 | Read strobe; advances to the next word |
| rd_data_o | output | DW | Oldest unread word |
| empty_o | output | 1 | Empty flag, consumer domain |

## Verification
full_o reacts on the same write edge that stores the word, so the bench reads it half a write cycle after each edge while it counts the burst. A write reaches empty_o after three read edges: two synchronizer flops and the flag register. A read reaches full_o after three write edges in the same way. The bench counts those edges from the causing edge and samples on the falling edge just before and just after the third one. The read clock is offset so that its edges never coincide with write edges, which keeps those edge counts exact. Stream checks compare every word against a scoreboard sequence and need no fixed latency.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/10ps
package xfifo_pkg;
  localparam int SYNC_STAGES = 2;

  function automatic int addr_bits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/10ps
module xfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = xfifo_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xfifo_wptr.sv
`timescale 1ns/10ps
module xfifo_wptr #(
  parameter int PW  = 6,
  parameter int CAP = 32,
  parameter int TH  = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wbin_o,
  output logic [PW-1:0] wgray_o,
  output logic [PW-1:0] rbin_sync_o,
  output logic          full_o
);
  localparam logic [PW-1:0] CapLim = PW'(CAP);
  localparam logic [PW-1:0] ThLim  = PW'(TH);

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, rbin_s, occ_now, occ_d;
  logic          full_q, wr_en;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync_i >> i);
  end

  assign occ_now = wbin_q - rbin_s;
  // hard guard only; the early flag keeps a well-behaved producer far from it
  assign wr_en   = wr_i && (occ_now < CapLim);
  assign wbin_d  = wbin_q + {{(PW-1){1'b0}}, wr_en};
  assign occ_d   = wbin_d - rbin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wbin_d ^ (wbin_d >> 1);
      full_q  <= (occ_d >= ThLim);
    end
  end

  assign wr_en_o     = wr_en;
  assign wbin_o      = wbin_q;
  assign wgray_o     = wgray_q;
  assign rbin_sync_o = rbin_s;
  assign full_o      = full_q;
endmodule

// File: rtl/xfifo_rptr.sv
`timescale 1ns/10ps
module xfifo_rptr #(
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [PW-1:0] wgray_sync_i,
  output logic [PW-1:0] rbin_o,
  output logic [PW-1:0] rgray_o,
  output logic [PW-1:0] wbin_sync_o,
  output logic          empty_o
);
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, wbin_s;
  logic          empty_q, rd_en;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync_i >> i);
  end

  assign rd_en  = rd_i && !empty_q;
  assign rbin_d = rbin_q + {{(PW-1){1'b0}}, rd_en};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rbin_d ^ (rbin_d >> 1);
      empty_q <= (rbin_d == wbin_s);
    end
  end

  assign rbin_o      = rbin_q;
  assign rgray_o     = rgray_q;
  assign wbin_sync_o = wbin_s;
  assign empty_o     = empty_q;
endmodule

// File: rtl/xfifo_cdc.sv
`timescale 1ns/10ps
module xfifo_cdc #(
  parameter int DEPTH = 16,
  parameter int SLACK = 4,
  parameter int RECOG = 1,
  parameter int DW    = 32
) (
  input  logic          wr_clk_i,
  input  logic          wr_rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  input  logic          rd_clk_i,
  input  logic          rd_rst_ni,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o
);
  localparam int AW  = xfifo_pkg::addr_bits(DEPTH + SLACK);
  localparam int PW  = AW + 1;
  localparam int CAP = 1 << AW;
  localparam int TH  = DEPTH - RECOG;

  logic [PW-1:0] wbin, wgray, wgray_at_r, wbin_at_r;
  logic [PW-1:0] rbin, rgray, rgray_at_w, rbin_at_w;
  logic          wr_en;
  logic [DW-1:0] mem_q [CAP];

  xfifo_wptr #(.PW(PW), .CAP(CAP), .TH(TH)) u_wptr (
    .clk_i        (wr_clk_i),
    .rst_ni       (wr_rst_ni),
    .wr_i         (wr_i),
    .rgray_sync_i (rgray_at_w),
    .wr_en_o      (wr_en),
    .wbin_o       (wbin),
    .wgray_o      (wgray),
    .rbin_sync_o  (rbin_at_w),
    .full_o       (full_o)
  );

  xfifo_rptr #(.PW(PW)) u_rptr (
    .clk_i        (rd_clk_i),
    .rst_ni       (rd_rst_ni),
    .rd_i         (rd_i),
    .wgray_sync_i (wgray_at_r),
    .rbin_o       (rbin),
    .rgray_o      (rgray),
    .wbin_sync_o  (wbin_at_r),
    .empty_o      (empty_o)
  );

  xfifo_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rd_clk_i),
    .rst_ni (rd_rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_at_r)
  );

  xfifo_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_at_w)
  );

  always_ff @(posedge wr_clk_i) begin
    if (wr_en) mem_q[wbin[AW-1:0]] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rbin[AW-1:0]];
endmodule

// File: rtl/xfifo_cdc_chk.sv
`timescale 1ns/10ps
module xfifo_cdc_chk #(
  parameter int PW  = 6,
  parameter int CAP = 32,
  parameter int TH  = 15
) (
  input logic          wr_clk_i,
  input logic          wr_rst_ni,
  input logic          rd_clk_i,
  input logic          rd_rst_ni,
  input logic          full_o,
  input logic          empty_o,
  input logic [PW-1:0] wbin_i,
  input logic [PW-1:0] rsync_i,
  input logic [PW-1:0] rbin_i,
  input logic [PW-1:0] wsync_i
);
  logic [PW-1:0] occ_w;
  assign occ_w = wbin_i - rsync_i;

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    occ_w <= PW'(CAP)); // R4

  AST_BELOW_LIMIT_WHEN_OPEN: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    !full_o |-> occ_w < PW'(TH)); // R2

  AST_FULL_DROPS_ON_SYNC: assert property (@(posedge wr_clk_i) disable iff (!wr_rst_ni)
    $fell(full_o) |-> $past(rsync_i) != $past(rsync_i, 2)); // R7

  AST_EMPTY_DROPS_ON_SYNC: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    $fell(empty_o) |-> $past(wsync_i) != $past(wsync_i, 2)); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge rd_clk_i) disable iff (!rd_rst_ni)
    !empty_o |-> rbin_i != wsync_i); // R8
endmodule

bind xfifo_cdc xfifo_cdc_chk #(.PW(PW), .CAP(CAP), .TH(TH)) u_chk (
  .wr_clk_i  (wr_clk_i),
  .wr_rst_ni (wr_rst_ni),
  .rd_clk_i  (rd_clk_i),
  .rd_rst_ni (rd_rst_ni),
  .full_o    (full_o),
  .empty_o   (empty_o),
  .wbin_i    (wbin),
  .rsync_i   (rbin_at_w),
  .rbin_i    (rbin),
  .wsync_i   (wbin_at_r)
);

// File: tb/tb_xfifo_cdc.sv
`timescale 1ns/10ps
module tb_xfifo_cdc;
  localparam int DEPTH = 16;
  localparam int SLACK = 4;
  localparam int RECOG = 1;
  localparam int DW    = 32;
  localparam int CAP   = 1 << $clog2(DEPTH + SLACK);
  localparam int TH    = DEPTH - RECOG;
  // read half period (x0.1 ns), words to stream, words expected back
  localparam int NVEC = 4;
  localparam int VEC [NVEC][3] = '{'{33, 50, 50}, '{100, 40, 40}, '{21, 60, 60}, '{77, 45, 45}};

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;
  real rd_half = 3.3;
  int checks = 0, failures = 0;
  int got_cnt, bad_cnt, sent_cnt;
  bit done = 1'b0;

  xfifo_cdc #(.DEPTH(DEPTH), .SLACK(SLACK), .RECOG(RECOG), .DW(DW)) dut (
    .wr_clk_i (wr_clk), .wr_rst_ni (wr_rst_n), .wr_i (wr_i), .wr_data_i (wr_data), .full_o (full),
    .rd_clk_i (rd_clk), .rd_rst_ni (rd_rst_n), .rd_i (rd_i), .rd_data_o (rd_data), .empty_o (empty)
  );

  always #2.5 wr_clk = ~wr_clk;  // 200 MHz
  // offset keeps read edges off the write-edge grid
  initial begin
    #0.73;
    forever #(rd_half) rd_clk = ~rd_clk;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_i = 1'b0; rd_i = 1'b0; wr_rst_n = 1'b0; rd_rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    repeat (3) @(negedge rd_clk);
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    repeat (2) @(negedge wr_clk);
    repeat (2) @(negedge rd_clk);
  endtask

  // producer sees full one write cycle late
  task automatic produce(int n, int base);
    bit full_seen = 1'b0;
    int sent = 0;
    while (sent < n) begin
      @(negedge wr_clk);
      if (!full_seen) begin
        wr_i = 1'b1; wr_data = 32'(base + sent); sent++;
      end else wr_i = 1'b0;
      full_seen = full;
    end
    @(negedge wr_clk);
    wr_i = 1'b0;
  endtask

  task automatic consume(int n, int base);
    got_cnt = 0; bad_cnt = 0;
    while (got_cnt < n) begin
      @(negedge rd_clk);
      if (!empty) begin
        if (rd_data !== 32'(base + got_cnt)) bad_cnt++;
        rd_i = 1'b1; got_cnt++;
      end else rd_i = 1'b0;
    end
    @(negedge rd_clk);
    rd_i = 1'b0;
  endtask

  task automatic drain(int base);
    got_cnt = 0; bad_cnt = 0;
    repeat (5) @(negedge rd_clk);
    while (!empty) begin
      if (rd_data !== 32'(base + got_cnt)) bad_cnt++;
      rd_i = 1'b1; got_cnt++;
      @(negedge rd_clk);
    end
    rd_i = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
    chk(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);

    // R5 streaming at several read/write ratios, R9 data sampled before strobe
    for (int i = 0; i < NVEC; i++) begin
      rd_half = VEC[i][0] / 10.0;
      fork
        produce(VEC[i][1], 1000 * (i + 1));
        consume(VEC[i][1], 1000 * (i + 1));
      join
      chk(got_cnt == VEC[i][2], "R5", "words received", got_cnt, VEC[i][2]);
      chk(bad_cnt == 0, "R5", "order mismatches", bad_cnt, 0);
    end

    // R8 strobes on empty, then R6 empty latency, R9 head word
    rd_half = 3.3;
    do_reset();
    @(negedge rd_clk); rd_i = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_i = 1'b0;
    repeat (2) @(negedge rd_clk);
    @(negedge wr_clk); wr_i = 1'b1; wr_data = 32'h0000_a5a5;
    @(posedge wr_clk); wr_i <= 1'b0;
    repeat (2) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty == 1'b1, "R6", "empty after 2 read edges", int'(empty), 1);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty == 1'b0, "R6", "empty after 3 read edges", int'(empty), 0);
    chk(rd_data == 32'h0000_a5a5, "R8", "word after ignored reads", int'(rd_data), 32'h0000_a5a5);
    rd_i = 1'b1;
    @(negedge rd_clk); rd_i = 1'b0;
    chk(empty == 1'b1, "R9", "empty after consuming head", int'(empty), 1);

    // R2/R3 early full with a late-reacting producer, reader stopped
    do_reset();
    begin
      bit full_prev = 1'b0;
      bit cur;
      sent_cnt = 0;
      forever begin
        @(negedge wr_clk);
        cur = full;
        if (sent_cnt == TH - 1) chk(cur == 1'b0, "R2", "full one write before limit", int'(cur), 0);
        if (sent_cnt == TH) chk(cur == 1'b1, "R2", "full at limit", int'(cur), 1);
        if (full_prev || sent_cnt >= 64) begin
          wr_i = 1'b0;
          break;
        end
        wr_i = 1'b1; wr_data = 32'(7000 + sent_cnt); sent_cnt++;
        full_prev = cur;
      end
    end
    chk(sent_cnt == DEPTH, "R3", "burst length", sent_cnt, DEPTH);

    // R7 full release latency after two reads
    repeat (2) @(negedge wr_clk);
    @(negedge rd_clk); rd_i = 1'b1;
    @(posedge rd_clk);
    @(posedge rd_clk); rd_i <= 1'b0;
    repeat (2) @(posedge wr_clk);
    @(negedge wr_clk);
    chk(full == 1'b1, "R7", "full 2 write edges after read", int'(full), 1);
    @(posedge wr_clk);
    @(negedge wr_clk);
    chk(full == 1'b0, "R7", "full 3 write edges after read", int'(full), 0);
    drain(7002);
    chk(got_cnt == DEPTH - 2, "R3", "remaining burst words", got_cnt, DEPTH - 2);
    chk(bad_cnt == 0, "R3", "burst order mismatches", bad_cnt, 0);

    // R4 writes beyond physical capacity are dropped
    do_reset();
    for (int k = 0; k < CAP + 8; k++) begin
      @(negedge wr_clk); wr_i = 1'b1; wr_data = 32'(5000 + k);
    end
    @(negedge wr_clk); wr_i = 1'b0;
    drain(5000);
    chk(got_cnt == CAP, "R4", "words kept at capacity", got_cnt, CAP);
    chk(bad_cnt == 0, "R4", "kept word mismatches", bad_cnt, 0);

    // R1 reset of an occupied queue
    for (int k = 0; k < 20; k++) begin
      @(negedge wr_clk); wr_i = 1'b1; wr_data = 32'(k);
    end
    @(negedge wr_clk); wr_i = 1'b0;
    repeat (6) @(negedge rd_clk);
    do_reset();
    chk(full == 1'b0, "R1", "full after reset when occupied", int'(full), 0);
    chk(empty == 1'b1, "R1", "empty after reset when occupied", int'(empty), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule